// File: doc/BRIEF.md
# Interrupt Target Routing Register Bank

This block stores, for every shared interrupt of a distributor, an 8-bit mask of the cores that may take it. From each mask it derives one delivery core: the lowest core whose mask bit is set, or core 0 when the mask is empty. The per-interrupt core indices leave the block on a flat vector for a later forwarding stage.

Software reaches the bank through a request/response register bus. Each interrupt ID owns one byte, and the byte offset is the interrupt ID. A word access covers four consecutive IDs, and a byte access covers one. The first 32 IDs are the private interrupts. They cannot be written, and reads of them return a fixed mask that names the requesting core. IDs beyond the implemented count read as zero, and writes to them are dropped.

The request channel is valid/ready. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Every accepted request, read or write, produces exactly one response on the following cycle. A response is held with unchanged data while `rsp_ready` is low. A new request is accepted only when no response is waiting or the waiting one is taken in the same cycle.

Top module: `tgt_route_bank`

## Requirements
- R1: Reset clears every shared mask to zero, drives every core index on `sel_core` to 0, and leaves `rsp_valid` low.
- R2: `req_ready` is high exactly when no response is waiting or `rsp_ready` is high. Each accepted request raises `rsp_valid` on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response and its data hold steady.
- R3: A word access (`req_size`=1) ignores `req_addr[1:0]` and covers IDs base..base+3, where base is `req_addr` with its two low bits cleared. ID base+i uses data bits [8i+7:8i].
- R4: A byte access (`req_size`=0) covers only ID `req_addr`. Write data comes from bits [7:0]. Read data is returned in bits [7:0] with bits [31:8] zero.
- R5: A write to a shared ID (32 to NUM_IRQ-1) stores the written byte as that ID's mask, and a later read returns it.
- R6: After a write to shared ID k, the field `sel_core[3(k-32)+2 : 3(k-32)]` holds the index of the lowest set bit of the new mask. The new value is visible from the clock edge that accepts the write.
- R7: A write of mask 0 to a shared ID sets that ID's core index to 0.
- R8: Writes to IDs 0 to 31 are ignored. Reads of those IDs return byte c of PRIV_MASKS, where c is `req_core`; by default that byte is 1 shifted left by c.
- R9: Reads of IDs at or above NUM_IRQ return zero bytes, and writes to them change nothing.
- R10: The response to a write carries zero data.
- R11: `sel_core` changes only on an edge that accepts a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte, 1 = word |
| req_addr | input | ADDR_W | Byte offset, equal to the interrupt ID |
| req_wdata | input | 32 | Write data |
| req_core | input | CORE_W | Index of the requesting core |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| sel_core | output | 3*(NUM_IRQ-32) | Chosen core per shared interrupt, 3 bits each, lowest ID first |

## Verification
The assertions check these properties on every cycle:
- the response handshake: a response follows each accepted request and holds while stalled;
- reset forcing every core index to 0;
- `sel_core` staying still when no write is accepted;
- zero data on out-of-range word reads and on the upper bytes of byte reads.

Several behaviours need data context, which only the bench scenarios can show:
- the lowest-set-bit choice over every mask value;
- the byte lanes of word accesses;
- the per-core private read value;
- the dropping of private and out-of-range writes.

// File: rtl/tgt_route_pkg.sv
package tgt_route_pkg;
  localparam int unsigned LANES    = 4;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned PRIV_IDS = 32;
  localparam int unsigned SEL_W    = 3;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } acc_size_e;

  // index of the lowest set bit, 0 for an empty mask
  function automatic logic [SEL_W-1:0] lowest_set(input logic [BYTE_W-1:0] m);
    logic [SEL_W-1:0] r;
    r = '0;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (m[i]) r = i[SEL_W-1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/tgt_lane_decode.sv
module tgt_lane_decode
  import tgt_route_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              size_word,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [LANES-1:0]  lane_en,
  output logic [31:0]       lane_bytes,
  output logic [ADDR_W-3:0] word_idx
);
  assign word_idx = addr[ADDR_W-1:2];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_en[l] = size_word || (addr[1:0] == 2'(l));
    assign lane_bytes[BYTE_W*l +: BYTE_W] =
      size_word ? wdata[BYTE_W*l +: BYTE_W] : wdata[BYTE_W-1:0];
  end
endmodule

// File: rtl/tgt_entry.sv
module tgt_entry
  import tgt_route_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned ENTRY_ID = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  logic [ADDR_W-3:0] word_idx,
  input  logic [LANES-1:0]  lane_en,
  input  logic [31:0]       lane_bytes,
  output logic [BYTE_W-1:0] mask,
  output logic [SEL_W-1:0]  sel
);
  localparam int unsigned     MY_LANE = ENTRY_ID % LANES;
  localparam logic [ADDR_W-3:0] MY_WORD = (ADDR_W-2)'(ENTRY_ID / LANES);

  logic              hit;
  logic [BYTE_W-1:0] new_mask;

  assign hit      = wr_acc && (word_idx == MY_WORD) && lane_en[MY_LANE];
  assign new_mask = lane_bytes[BYTE_W*MY_LANE +: BYTE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      sel  <= '0;
    end else if (hit) begin
      mask <= new_mask;
      sel  <= lowest_set(new_mask);
    end
  end
endmodule

// File: rtl/tgt_read_mux.sv
module tgt_read_mux
  import tgt_route_pkg::*;
#(
  parameter int unsigned NUM_IRQ    = 64,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned CORE_W     = 2,
  parameter logic [63:0] PRIV_MASKS = 64'h8040_2010_0804_0201
) (
  input  logic [ADDR_W-3:0]               word_idx,
  input  logic [1:0]                      byte_sel,
  input  logic                            size_word,
  input  logic [CORE_W-1:0]               core,
  input  logic [(NUM_IRQ-PRIV_IDS)*8-1:0] masks,
  output logic [31:0]                     rdata
);
  localparam int unsigned NUM_SHARED = NUM_IRQ - PRIV_IDS;

  logic [31:0] word_val;
  logic [7:0]  priv_byte;

  assign priv_byte = PRIV_MASKS[BYTE_W*int'(core) +: BYTE_W];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] id;
    int unsigned       idx;
    assign id = {word_idx, 2'(l)};
    always_comb begin
      idx = 0;
      if (int'(id) >= PRIV_IDS && int'(id) < NUM_IRQ) idx = int'(id) - PRIV_IDS;
      if (int'(id) < PRIV_IDS)
        word_val[BYTE_W*l +: BYTE_W] = priv_byte;
      else if (int'(id) < NUM_IRQ && idx < NUM_SHARED)
        word_val[BYTE_W*l +: BYTE_W] = masks[BYTE_W*idx +: BYTE_W];
      else
        word_val[BYTE_W*l +: BYTE_W] = '0;
    end
  end

  always_comb begin
    if (size_word) rdata = word_val;
    else           rdata = {24'h0, word_val[BYTE_W*byte_sel +: BYTE_W]};
  end
endmodule

// File: rtl/tgt_route_bank.sv
module tgt_route_bank
  import tgt_route_pkg::*;
#(
  parameter int unsigned NUM_IRQ    = 64,
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned ADDR_W     = 8,
  parameter logic [63:0] PRIV_MASKS = 64'h8040_2010_0804_0201,
  localparam int unsigned CORE_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned NUM_SHARED = NUM_IRQ - PRIV_IDS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic                        req_size,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [31:0]                 req_wdata,
  input  logic [CORE_W-1:0]           req_core,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [31:0]                 rsp_rdata,
  output logic [SEL_W*NUM_SHARED-1:0] sel_core
);
  logic                    acc;
  logic                    size_word;
  logic [LANES-1:0]        lane_en;
  logic [31:0]             lane_bytes;
  logic [ADDR_W-3:0]       word_idx;
  logic [NUM_SHARED*8-1:0] masks;
  logic [31:0]             rd_word;

  assign size_word = (acc_size_e'(req_size) == SZ_WORD);
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  tgt_lane_decode #(.ADDR_W(ADDR_W)) u_dec (
    .size_word (size_word),
    .addr      (req_addr),
    .wdata     (req_wdata),
    .lane_en   (lane_en),
    .lane_bytes(lane_bytes),
    .word_idx  (word_idx)
  );

  for (genvar j = 0; j < NUM_SHARED; j++) begin : g_ent
    tgt_entry #(.ADDR_W(ADDR_W), .ENTRY_ID(PRIV_IDS + j)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_acc    (acc && req_write),
      .word_idx  (word_idx),
      .lane_en   (lane_en),
      .lane_bytes(lane_bytes),
      .mask      (masks[8*j +: 8]),
      .sel       (sel_core[SEL_W*j +: SEL_W])
    );
  end

  tgt_read_mux #(
    .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .CORE_W(CORE_W), .PRIV_MASKS(PRIV_MASKS)
  ) u_rd (
    .word_idx (word_idx),
    .byte_sel (req_addr[1:0]),
    .size_word(size_word),
    .core     (req_core),
    .masks    (masks),
    .rdata    (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? 32'h0 : rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tgt_route_bank_chk.sv
module tgt_route_bank_chk #(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned SEL_BITS = 96
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic                req_size,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [31:0]         rsp_rdata,
  input logic [SEL_BITS-1:0] sel_core
);
  logic acc;
  assign acc = req_valid && req_ready;

  p_reset_sel_r1: assert property (@(posedge clk) !rst_n |=> (sel_core == '0) && !rsp_valid);

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata));

  p_byte_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && !req_size) |=> rsp_rdata[31:8] == 24'h0);

  p_oor_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_size && (int'(req_addr[ADDR_W-1:2]) >= NUM_IRQ / 4))
      |=> rsp_rdata == 32'h0);

  p_write_rsp_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> rsp_rdata == 32'h0);

  p_sel_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && req_write) |=> $stable(sel_core));
endmodule

bind tgt_route_bank tgt_route_bank_chk #(
  .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .SEL_BITS(3 * (NUM_IRQ - 32))
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .sel_core(sel_core)
);

// File: tb/tb_tgt_route_bank.sv
`timescale 1ns/1ps
module tb_tgt_route_bank;
  localparam int NIRQ = 64;
  localparam int NSH  = NIRQ - 32;
  localparam int AW   = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic              req_size = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic [1:0]        req_core = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [31:0]       rsp_rdata;
  logic [3*NSH-1:0]  sel_core;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  logic [7:0] model [NIRQ];

  always #2 clk = ~clk;

  tgt_route_bank #(.NUM_IRQ(NIRQ), .NUM_CORES(4), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_core(req_core), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .sel_core(sel_core)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] low_bit(input logic [7:0] v);
    int n = 0;
    if (v == 0) return 3'd0;
    while (!v[0]) begin v = v >> 1; n++; end
    return 3'(n);
  endfunction

  function automatic logic [3*NSH-1:0] exp_sel();
    logic [3*NSH-1:0] r;
    for (int j = 0; j < NSH; j++) r[3*j +: 3] = low_bit(model[32 + j]);
    return r;
  endfunction

  // expected byte for an ID read by core c
  function automatic logic [7:0] exp_byte(input int id, input int c);
    if (id < 32) return 8'(1 << c);
    if (id < NIRQ) return model[id];
    return 8'h0;
  endfunction

  task automatic xfer(input bit wr, input bit sz, input int addr, input logic [31:0] wd,
                      input int core, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = AW'(addr); req_wdata = wd; req_core = 2'(core);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    check("R2 response present", 128'(rsp_valid), 128'(1));
  endtask

  task automatic mwrite(input bit sz, input int addr, input logic [31:0] wd);
    logic [31:0] rd;
    xfer(1'b1, sz, addr, wd, 0, rd);
    check("R10 write response data", 128'(rd), 128'(0));
    if (sz) begin
      for (int l = 0; l < 4; l++) begin
        int id = (addr & ~3) + l;
        if (id >= 32 && id < NIRQ) model[id] = wd[8*l +: 8];
      end
    end else if (addr >= 32 && addr < NIRQ) model[addr] = wd[7:0];
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [3*NSH-1:0] snap;
    for (int i = 0; i < NIRQ; i++) model[i] = 8'h0;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", 128'(rsp_valid), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sel_core after reset", 128'(sel_core), 128'(0));
    check("R1 rsp_valid after reset", 128'(rsp_valid), 128'(0));
    check("R2 ready when idle", 128'(req_ready), 128'(1));
    xfer(1'b0, 1'b1, 32, 32'h0, 0, rd);
    check("R1 shared masks zero", 128'(rd), 128'(0));

    // R5 R6 R7: byte writes to every shared ID
    for (int id = 32; id < NIRQ; id++) begin
      logic [7:0] v = (id % 9 == 0) ? 8'h00 : 8'((id * 37 + 5) & 8'hFF);
      mwrite(1'b0, id, {24'hABCDEF, v});
      check("R6 R7 sel after byte write", 128'(sel_core), 128'(exp_sel()));
    end

    // R3 R8: word reads of every word with rotating requesting core
    for (int w = 0; w < NIRQ / 4; w++) begin
      int c = w % 4;
      xfer(1'b0, 1'b1, 4 * w + (w % 4), 32'h0, c, rd);
      check("R3 R5 R8 word read",
            128'(rd), 128'({exp_byte(4*w+3, c), exp_byte(4*w+2, c), exp_byte(4*w+1, c), exp_byte(4*w, c)}));
    end

    // R4: byte reads of every ID
    for (int id = 0; id < NIRQ; id++) begin
      xfer(1'b0, 1'b0, id, 32'hFFFF_FFFF, 2, rd);
      check("R4 R8 byte read", 128'(rd), 128'({24'h0, exp_byte(id, 2)}));
    end

    // R3: word writes to shared words, lane order checked through sel and reads
    for (int w = 8; w < NIRQ / 4; w++) begin
      mwrite(1'b1, 4 * w + 2, {8'(8'h80 >> (w % 8)), 8'h00, 8'(w * 6), 8'(8'h01 << (w % 8))});
      check("R3 R6 sel after word write", 128'(sel_core), 128'(exp_sel()));
      xfer(1'b0, 1'b1, 4 * w, 32'h0, 1, rd);
      check("R3 R5 word readback",
            128'(rd), 128'({model[4*w+3], model[4*w+2], model[4*w+1], model[4*w]}));
    end

    // R6 R7: every mask value on one entry (ID 45)
    for (int v = 0; v < 256; v++) begin
      mwrite(1'b0, 45, 32'(v));
      check("R6 R7 lowest set bit", 128'(sel_core[3*13 +: 3]), 128'(low_bit(8'(v))));
    end

    // R8: private writes ignored
    snap = sel_core;
    for (int w = 0; w < 8; w++) begin
      mwrite(1'b1, 4 * w, 32'hFFFF_FFFF);
      mwrite(1'b0, 4 * w + 1, 32'h0000_00FF);
      check("R8 R11 sel unchanged by private write", 128'(sel_core), 128'(snap));
      for (int c = 0; c < 4; c++) begin
        xfer(1'b0, 1'b1, 4 * w, 32'h0, c, rd);
        check("R8 private read per core", 128'(rd), 128'({4{8'(1 << c)}}));
      end
    end

    // R9: out-of-range accesses
    for (int w = NIRQ / 4; w < (1 << AW) / 4; w++) begin
      mwrite(1'b1, 4 * w, 32'hFFFF_FFFF);
      check("R9 sel unchanged by out-of-range write", 128'(sel_core), 128'(snap));
      xfer(1'b0, 1'b1, 4 * w, 32'h0, 0, rd);
      check("R9 out-of-range word read", 128'(rd), 128'(0));
      xfer(1'b0, 1'b0, 4 * w + 3, 32'h0, 0, rd);
      check("R9 out-of-range byte read", 128'(rd), 128'(0));
    end

    // R2: back-pressure on the response channel
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_size = 1'b1; req_addr = 8'd36; req_core = 2'd0;
    @(posedge clk);
    @(negedge clk);
    rd = rsp_rdata;
    check("R2 stalled read data", 128'(rd),
          128'({model[39], model[38], model[37], model[36]}));
    req_write = 1'b1; req_size = 1'b0; req_addr = 8'd33; req_wdata = 32'h80;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R2 valid held", 128'(rsp_valid), 128'(1));
      check("R2 data held", 128'(rsp_rdata), 128'(rd));
      check("R2 ready low while stalled", 128'(req_ready), 128'(0));
      check("R11 sel held while stalled", 128'(sel_core), 128'(exp_sel()));
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    model[33] = 8'h80;
    check("R2 R6 write accepted on release", 128'(sel_core[3 +: 3]), 128'(7));
    check("R2 new response present", 128'(rsp_valid), 128'(1));
    @(negedge clk);
    check("R2 response drained", 128'(rsp_valid), 128'(0));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule